// File: doc/BRIEF.md
# Sleep-Aligned Periodic Timer Controller

This block keeps a 16-bit periodic timer and a 20-bit count of its wraps on a fast system clock. Software starts and stops it with a run bit. A sync bit selects how that bit acts. With sync low, the run bit takes effect on the next system clock. With sync high, the change waits for a rising edge of a slow 32.768 kHz clock. That clock enters asynchronously and is first brought through a flop synchronizer.

A synchronous stop lets the timer keep counting until the slow edge. At that edge the timer halts and records the free-running 24-bit sleep counter.

A synchronous start holds the timer idle until the slow edge. At that edge the block snapshots the sleep counter. It then asks an external calculator for compensated timer and wrap-count values, offering four inputs: the snapshot, the recorded stop count, and the frozen timer and wrap count. It accepts the answer on a one-cycle acknowledge. It enters RUN a fixed 75 system cycles after the edge, or later if the answer is late. This makes the sleep interval look as if the timer had never paused.

Top module: `sst_ctrl`

## Requirements
- R1: After reset, the timer value, the wrap count and the stored sleep count are 0, and running and the reload request are low.
- R2: While running, the timer value rises by one each system cycle. After the value period-1 it returns to 0 and the wrap count rises by one. A period of 0 acts as 65536.
- R3: The wrap count wraps from 0xFFFFF to 0.
- R4: With sync low, setting run while idle starts counting at the next system clock, with no reload request.
- R5: With sync low, clearing run while running stops the timer at the next system clock. That clock does not advance the value, and the value then holds.
- R6: With sync high, clearing run while running keeps the timer counting until a rising edge of the slow clock has passed two synchronizer flops. The timer halts on the third system edge after the slow clock rises, and that edge adds no count.
- R7: On that synchronous halt, the sleep counter input is stored and shown on the stored-sleep output. The stored value changes at no other time except reset.
- R8: With sync high, setting run while idle keeps the timer idle, with no request, until the synchronized slow edge. At that edge the request rises, and the block presents four values: the sleep count snapshot, the stored count, the frozen timer value and the frozen wrap count.
- R9: The request stays high until an acknowledge is seen. The returned values are taken in the cycle of the acknowledge.
- R10: When the acknowledge comes in time, RUN starts exactly 75 system edges after the edge that sampled the slow edge. The returned values are then loaded, and counting continues from them.
- R11: When the acknowledge comes late, RUN and the load happen at the edge that samples the acknowledge.
- R12: While not running (idle, waiting for a start edge, or reloading), the timer value and wrap count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Run request bit |
| sync_i | input | 1 | 1: align start/stop to slow-clock edges |
| period_i | input | 16 | Timer period; 0 means 65536 |
| slow_clk_i | input | 1 | Asynchronous 32.768 kHz clock |
| sleep_cnt_i | input | 24 | Free-running sleep counter |
| calc_req_o | output | 1 | Reload request to calculator |
| calc_cur_sleep_o | output | 24 | Sleep count snapshot at the start edge |
| calc_stored_sleep_o | output | 24 | Sleep count stored at the last synchronous stop |
| calc_cur_tval_o | output | 16 | Frozen timer value |
| calc_cur_ovf_o | output | 20 | Frozen wrap count |
| calc_ack_i | input | 1 | One-cycle acknowledge with result |
| calc_tval_i | input | 16 | Compensated timer value |
| calc_ovf_i | input | 20 | Compensated wrap count |
| tval_o | output | 16 | Timer value |
| ovf_o | output | 20 | Wrap count |
| running_o | output | 1 | Timer is counting (running or stop pending) |

## Verification
A wrong sequencer state appears at the ports within one system cycle. The symptoms are a running flag that changes at the wrong edge, a timer value that moves while it should hold, or a request that rises outside a reload. A miscounted reload wait shifts the cycle in which running rises and the loaded value appears, so the bench samples both one edge before and exactly at edge 75. A bad edge detector or synchronizer depth moves the halt point, which shows as a timer value one count off at the stop.

// File: rtl/sst_pkg.sv
// Shared types for the sleep-aligned timer controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sst_pkg;

    // Sequencer states of the timer controller.
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RUN        = 3'd1,
        ST_STOP_PEND  = 3'd2,
        ST_START_PEND = 3'd3,
        ST_RELOAD     = 3'd4
    } sst_state_e;

endpackage

// File: rtl/sst_edge_sync.sv
// Brings an asynchronous slow clock into the system domain through a flop
// chain and flags its rising edge for one system cycle.
// Assumes: the slow clock is far slower than clk, so no edge is missed.
module sst_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= async_i;
            end
        end else begin : g_next
            // Later stages settle the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[gi] <= 1'b0;
                else        sync_q[gi] <= sync_q[gi-1];
            end
        end
    end

    // Remember the last synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Rising edge: synchronized sample is 1 and the previous one was 0.
    assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/sst_counter.sv
// Periodic timer with wrap counter. Counts 0..period-1 when enabled; each
// wrap advances the wrap counter modulo 2^OW. A load has priority.
// Assumes: a period of 0 gives the full 2^TW range through modular subtract.
module sst_counter #(
    parameter int TW = 16,
    parameter int OW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          load_i,
    input  logic [TW-1:0] load_tval_i,
    input  logic [OW-1:0] load_ovf_i,
    input  logic [TW-1:0] period_i,
    output logic [TW-1:0] tval_o,
    output logic [OW-1:0] ovf_o
);

    logic [TW-1:0] tval_q;
    logic [OW-1:0] ovf_q;
    logic          wrap;

    // Last value of the period reached.
    assign wrap = (tval_q == period_i - TW'(1));

    // Load, count or hold the timer and wrap count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tval_q <= '0;
            ovf_q  <= '0;
        end else if (load_i) begin
            tval_q <= load_tval_i;
            ovf_q  <= load_ovf_i;
        end else if (inc_i) begin
            if (wrap) begin
                tval_q <= '0;
                ovf_q  <= ovf_q + OW'(1);
            end else begin
                tval_q <= tval_q + TW'(1);
            end
        end
    end

    assign tval_o = tval_q;
    assign ovf_o  = ovf_q;

endmodule

// File: rtl/sst_seq.sv
// Start/stop sequencer: immediate or slow-edge-aligned start and stop,
// sleep count capture, reload request handshake and fixed reload delay.
// Assumes: acknowledge is a one-cycle pulse that carries its data.
module sst_seq
    import sst_pkg::*;
#(
    parameter int TW            = 16,
    parameter int OW            = 20,
    parameter int SW            = 24,
    parameter int RELOAD_CYCLES = 75
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          sync_i,
    input  logic          edge_i,
    input  logic [SW-1:0] sleep_cnt_i,
    input  logic          calc_ack_i,
    input  logic [TW-1:0] calc_tval_i,
    input  logic [OW-1:0] calc_ovf_i,
    output sst_state_e    state_o,
    output logic          inc_o,
    output logic          load_o,
    output logic [TW-1:0] load_tval_o,
    output logic [OW-1:0] load_ovf_o,
    output logic          calc_req_o,
    output logic [SW-1:0] cur_sleep_o,
    output logic [SW-1:0] stored_sleep_o
);

    localparam int            CW   = $clog2(RELOAD_CYCLES + 1);
    localparam logic [CW-1:0] RC_V = CW'(RELOAD_CYCLES);

    sst_state_e    state_q, nxt_state;
    logic [CW-1:0] wcnt_q;
    logic          req_q, got_q;
    logic [TW-1:0] hold_tval_q;
    logic [OW-1:0] hold_ovf_q;
    logic [SW-1:0] cur_sleep_q, stored_q;
    logic          ack_take, ready, capture, start, load;

    assign ack_take = calc_ack_i & req_q;
    assign ready    = got_q | ack_take;

    // Next state, count enable and one-cycle events.
    always_comb begin
        nxt_state = state_q;
        inc_o     = 1'b0;
        capture   = 1'b0;
        start     = 1'b0;
        load      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i) nxt_state = sync_i ? ST_START_PEND : ST_RUN;
            end
            ST_RUN: begin
                if (run_i) begin
                    inc_o = 1'b1;
                end else if (sync_i) begin
                    inc_o     = 1'b1;
                    nxt_state = ST_STOP_PEND;
                end else begin
                    nxt_state = ST_IDLE;
                end
            end
            ST_STOP_PEND: begin
                if (run_i) begin
                    inc_o     = 1'b1;
                    nxt_state = ST_RUN;
                end else if (edge_i) begin
                    capture   = 1'b1;
                    nxt_state = ST_IDLE;
                end else begin
                    inc_o = 1'b1;
                end
            end
            ST_START_PEND: begin
                if (!run_i) begin
                    nxt_state = ST_IDLE;
                end else if (edge_i) begin
                    start     = 1'b1;
                    nxt_state = ST_RELOAD;
                end
            end
            ST_RELOAD: begin
                if (wcnt_q >= RC_V && ready) begin
                    load      = 1'b1;
                    nxt_state = ST_RUN;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt_state;
    end

    // Reload delay counter: 1 at the start edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  wcnt_q <= '0;
        else if (start)                              wcnt_q <= CW'(1);
        else if (state_q == ST_RELOAD && wcnt_q < RC_V) wcnt_q <= wcnt_q + CW'(1);
    end

    // Request flag held from the start edge until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)        req_q <= 1'b0;
        else if (start)    req_q <= 1'b1;
        else if (ack_take) req_q <= 1'b0;
    end

    // Result-present flag, cleared when the result is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)        got_q <= 1'b0;
        else if (load)     got_q <= 1'b0;
        else if (ack_take) got_q <= 1'b1;
    end

    // Hold the returned values until the reload delay has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_tval_q <= '0;
            hold_ovf_q  <= '0;
        end else if (ack_take) begin
            hold_tval_q <= calc_tval_i;
            hold_ovf_q  <= calc_ovf_i;
        end
    end

    // Snapshot of the sleep count at the start edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     cur_sleep_q <= '0;
        else if (start) cur_sleep_q <= sleep_cnt_i;
    end

    // Sleep count stored at a synchronous halt.
    always_ff @(posedge clk) begin
        if (!rst_n)       stored_q <= '0;
        else if (capture) stored_q <= sleep_cnt_i;
    end

    assign state_o        = state_q;
    assign load_o         = load;
    assign load_tval_o    = got_q ? hold_tval_q : calc_tval_i;
    assign load_ovf_o     = got_q ? hold_ovf_q  : calc_ovf_i;
    assign calc_req_o     = req_q;
    assign cur_sleep_o    = cur_sleep_q;
    assign stored_sleep_o = stored_q;

endmodule

// File: rtl/sst_ctrl.sv
// Top of the sleep-aligned timer controller: slow-clock edge detector,
// start/stop sequencer and periodic counter.
// Assumes: clk is the fast system clock; slow_clk_i is asynchronous to it.
module sst_ctrl
    import sst_pkg::*;
#(
    parameter int TVAL_W        = 16,
    parameter int OVF_W         = 20,
    parameter int SLEEP_W       = 24,
    parameter int RELOAD_CYCLES = 75,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               sync_i,
    input  logic [TVAL_W-1:0]  period_i,
    input  logic               slow_clk_i,
    input  logic [SLEEP_W-1:0] sleep_cnt_i,
    output logic               calc_req_o,
    output logic [SLEEP_W-1:0] calc_cur_sleep_o,
    output logic [SLEEP_W-1:0] calc_stored_sleep_o,
    output logic [TVAL_W-1:0]  calc_cur_tval_o,
    output logic [OVF_W-1:0]   calc_cur_ovf_o,
    input  logic               calc_ack_i,
    input  logic [TVAL_W-1:0]  calc_tval_i,
    input  logic [OVF_W-1:0]   calc_ovf_i,
    output logic [TVAL_W-1:0]  tval_o,
    output logic [OVF_W-1:0]   ovf_o,
    output logic               running_o
);

    sst_state_e        state;
    logic              slow_rise;
    logic              inc, load;
    logic [TVAL_W-1:0] load_tval, tval;
    logic [OVF_W-1:0]  load_ovf, ovf;

    sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (slow_clk_i),
        .rise_o  (slow_rise)
    );

    sst_seq #(
        .TW(TVAL_W), .OW(OVF_W), .SW(SLEEP_W), .RELOAD_CYCLES(RELOAD_CYCLES)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_i          (run_i),
        .sync_i         (sync_i),
        .edge_i         (slow_rise),
        .sleep_cnt_i    (sleep_cnt_i),
        .calc_ack_i     (calc_ack_i),
        .calc_tval_i    (calc_tval_i),
        .calc_ovf_i     (calc_ovf_i),
        .state_o        (state),
        .inc_o          (inc),
        .load_o         (load),
        .load_tval_o    (load_tval),
        .load_ovf_o     (load_ovf),
        .calc_req_o     (calc_req_o),
        .cur_sleep_o    (calc_cur_sleep_o),
        .stored_sleep_o (calc_stored_sleep_o)
    );

    sst_counter #(.TW(TVAL_W), .OW(OVF_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_i       (inc),
        .load_i      (load),
        .load_tval_i (load_tval),
        .load_ovf_i  (load_ovf),
        .period_i    (period_i),
        .tval_o      (tval),
        .ovf_o       (ovf)
    );

    assign tval_o          = tval;
    assign ovf_o           = ovf;
    assign calc_cur_tval_o = tval;
    assign calc_cur_ovf_o  = ovf;
    assign running_o       = (state == ST_RUN) || (state == ST_STOP_PEND);

endmodule

// File: rtl/sst_ctrl_chk.sv
// Property checker for sst_ctrl, attached with bind.
// Assumes: synchronous active-low reset on clk.
module sst_ctrl_chk
    import sst_pkg::*;
#(
    parameter int TW = 16,
    parameter int OW = 20,
    parameter int SW = 24,
    parameter int RC = 75
) (
    input logic          clk,
    input logic          rst_n,
    input sst_state_e    state_i,
    input logic          running_i,
    input logic [TW-1:0] tval_i,
    input logic [OW-1:0] ovf_i,
    input logic [SW-1:0] stored_i,
    input logic          req_i,
    input logic          ack_i
);

    localparam int            CW   = $clog2(RC + 2);
    localparam logic [CW-1:0] RC_V = CW'(RC);

    logic [CW-1:0] rl_cnt;

    // Cycles spent in reload, saturating above the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rl_cnt <= '0;
        else if (state_i != ST_RELOAD) rl_cnt <= '0;
        else if (rl_cnt <= RC_V)       rl_cnt <= rl_cnt + CW'(1);
    end

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE && $past(state_i) == ST_IDLE) |-> ($stable(tval_i) && $stable(ovf_i))); // R12
    AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running_i) && running_i && ovf_i != $past(ovf_i)) |-> (ovf_i == $past(ovf_i) + OW'(1) && tval_i == '0)); // R2
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running_i) && running_i && $past(ovf_i) == '1 && ovf_i != $past(ovf_i)) |-> (ovf_i == '0)); // R3
    AST_STORE_AT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stored_i) |-> ($past(state_i) == ST_STOP_PEND && state_i == ST_IDLE)); // R7
    AST_REQ_IN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> (state_i == ST_RELOAD)); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ack_i) |=> req_i); // R9
    AST_RELOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_i) == ST_RELOAD && state_i == ST_RUN) |-> (rl_cnt >= RC_V)); // R10

endmodule

bind sst_ctrl sst_ctrl_chk #(
    .TW(TVAL_W), .OW(OVF_W), .SW(SLEEP_W), .RC(RELOAD_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_i   (state),
    .running_i (running_o),
    .tval_i    (tval_o),
    .ovf_i     (ovf_o),
    .stored_i  (calc_stored_sleep_o),
    .req_i     (calc_req_o),
    .ack_i     (calc_ack_i)
);

// File: tb/tb_sst_ctrl.sv
module tb_sst_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0, sync_i = 1'b0, slow_clk_i = 1'b0;
    logic [15:0] period_i = '0;
    logic [23:0] sleep_cnt_i = '0;
    logic        calc_req_o, calc_ack_i = 1'b0, running_o;
    logic [23:0] calc_cur_sleep_o, calc_stored_sleep_o;
    logic [15:0] calc_cur_tval_o, calc_tval_i = '0, tval_o;
    logic [19:0] calc_cur_ovf_o, calc_ovf_i = '0, ovf_o;

    int checks = 0;
    int fails  = 0;
    logic [15:0] frozen;

    always #5 clk = ~clk;

    sst_ctrl dut (.*);

    typedef struct packed {
        logic [15:0] per;
        logic [31:0] n;
        logic [15:0] exp_t;
        logic [19:0] exp_o;
    } vec_t;

    // Free-running counts with sync low: period, cycles, expected value, wraps.
    localparam vec_t VEC [6] = '{
        '{16'd10,   32'd25,    16'd5,    20'd2},
        '{16'd1,    32'd7,     16'd0,    20'd7},
        '{16'd3,    32'd3,     16'd0,    20'd1},
        '{16'd1000, 32'd999,   16'd999,  20'd0},
        '{16'd0,    32'd70000, 16'd4464, 20'd1},
        '{16'd5,    32'd0,     16'd0,    20'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run_i = 1'b0; sync_i = 1'b0; slow_clk_i = 1'b0; calc_ack_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 tval", tval_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 running", running_o, 0);
        chk("R1 req", calc_req_o, 0);
        chk("R1 stored", calc_stored_sleep_o, 0);

        // Vector loop: R2 counting, R4 immediate start, R5 immediate stop
        foreach (VEC[i]) begin
            do_reset();
            period_i = VEC[i].per;
            run_i = 1'b1;
            @(negedge clk);
            chk("R4 start", running_o, 1);
            chk("R4 no req", calc_req_o, 0);
            repeat (VEC[i].n) @(negedge clk);
            run_i = 1'b0;
            @(negedge clk);
            chk("R5 stopped", running_o, 0);
            chk("R2 tval", tval_o, VEC[i].exp_t);
            chk("R2 ovf", ovf_o, VEC[i].exp_o);
            repeat (3) @(negedge clk);
            chk("R5 held", tval_o, VEC[i].exp_t);
        end

        // R6/R7 synchronous stop
        do_reset();
        period_i = 16'd0;
        run_i = 1'b1;
        @(negedge clk);
        repeat (30) @(negedge clk);
        chk("R2 tval 30", tval_o, 30);
        run_i = 1'b0; sync_i = 1'b1; slow_clk_i = 1'b1; sleep_cnt_i = 24'h123456;
        @(negedge clk);
        chk("R6 pending running", running_o, 1);
        chk("R6 pending tval", tval_o, 31);
        @(negedge clk);
        chk("R6 still counting", tval_o, 32);
        @(negedge clk);
        chk("R6 halted", running_o, 0);
        chk("R6 halt tval", tval_o, 32);
        chk("R7 stored", calc_stored_sleep_o, 24'h123456);
        sleep_cnt_i = 24'h000100;
        repeat (5) @(negedge clk);
        chk("R12 idle hold", tval_o, 32);
        chk("R7 stored hold", calc_stored_sleep_o, 24'h123456);

        // R8/R10 synchronous start with early acknowledge
        slow_clk_i = 1'b0;
        repeat (4) @(negedge clk);
        run_i = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 waits idle", running_o, 0);
        chk("R8 no req yet", calc_req_o, 0);
        slow_clk_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 req", calc_req_o, 1);
        chk("R8 cur sleep", calc_cur_sleep_o, 24'h000100);
        chk("R8 stored", calc_stored_sleep_o, 24'h123456);
        chk("R8 cur tval", calc_cur_tval_o, 32);
        chk("R8 cur ovf", calc_cur_ovf_o, 0);
        repeat (5) @(negedge clk);
        calc_ack_i = 1'b1; calc_tval_i = 16'h0200; calc_ovf_i = 20'h00ABC;
        @(negedge clk);
        calc_ack_i = 1'b0; calc_tval_i = 16'h0; calc_ovf_i = 20'h0;
        chk("R9 req dropped", calc_req_o, 0);
        repeat (68) @(negedge clk);
        chk("R10 not yet run", running_o, 0);
        chk("R12 reload hold", tval_o, 32);
        @(negedge clk);
        chk("R10 run at 75", running_o, 1);
        chk("R10 loaded tval", tval_o, 16'h0200);
        chk("R10 loaded ovf", ovf_o, 20'h00ABC);
        @(negedge clk);
        chk("R10 continues", tval_o, 16'h0201);

        // R5 immediate stop from a reloaded run
        frozen = tval_o;
        run_i = 1'b0; sync_i = 1'b0;
        @(negedge clk);
        chk("R5 stop", running_o, 0);
        chk("R5 frozen", tval_o, frozen);

        // R11/R3 late acknowledge and wrap-count rollover
        slow_clk_i = 1'b0;
        repeat (4) @(negedge clk);
        run_i = 1'b1; sync_i = 1'b1;
        repeat (3) @(negedge clk);
        slow_clk_i = 1'b1;
        repeat (100) @(negedge clk);
        chk("R11 waiting", running_o, 0);
        chk("R9 req held", calc_req_o, 1);
        chk("R8 cur tval late", calc_cur_tval_o, frozen);
        calc_ack_i = 1'b1; calc_tval_i = 16'hFFFF; calc_ovf_i = 20'hFFFFF;
        @(negedge clk);
        calc_ack_i = 1'b0;
        chk("R11 run on ack", running_o, 1);
        chk("R11 tval", tval_o, 16'hFFFF);
        chk("R11 ovf", ovf_o, 20'hFFFFF);
        @(negedge clk);
        chk("R3 tval wrap", tval_o, 0);
        chk("R3 ovf wrap", ovf_o, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule